// File: doc/BRIEF.md
# Link Training Bring-Up Sequencer

This block brings a serial link up in two stages. When started, it caps the link's advertised top speed at the first generation and enables training. It then waits for the partner to report a trained link. If the configured top generation is two or higher, it lifts the cap to the second generation and requests a directed speed change. It polls the self-clearing request bit until the hardware drops it, waits for retraining to settle, and reads the negotiated speed back from the link status register.

The block reaches the link core's configuration space through a simple request/acknowledge master port that carries 32-bit data. It reaches the PHY's 16-bit internal registers through a second port of the same kind. If bring-up fails, either because the link never comes up or because the speed change never completes, the block runs a recovery pulse on the PHY receiver override register and then reports failure. Every register update is a read-modify-write, so fields the block does not own keep their values. A single start pulse runs the whole sequence. The sequence ends in a one-cycle done pulse, with a fail flag beside it when bring-up did not succeed.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, train_en, done, fail, reg_req and phy_req are 0 and cur_speed is 0.
- R2: On an accepted start, the block reads the capability register at CAP_ADDR and writes it back with bits 3:0 set to 1 and all other bits unchanged. train_en stays 0 during that write and becomes 1 after it, and it holds 1 until the next accepted start.
- R3: The link counts as trained only when link_up is 1 and link_training is 0 in the same cycle. If this does not happen within link_timeout cycles of entering a wait, the block takes the failure path, and that happens no earlier than link_timeout cycles after train_en rises.
- R4: When max_gen is 2 or 3 and the link has trained, the block rewrites bits 3:0 of CAP_ADDR to 2 (other bits kept). It then sets bit 17 of the speed-control register at SPD_ADDR by read-modify-write, keeping all other bits.
- R5: After setting bit 17, the block reads SPD_ADDR until bit 17 reads 0, and it makes at most POLL_MAX such reads. If the last allowed read still shows bit 17 at 1, bring-up fails.
- R6: When max_gen is 0 (unconfigured) or 1, the block never accesses SPD_ADDR and writes CAP_ADDR exactly once.
- R7: On success, after the final trained-link wait, the block reads STAT_ADDR and presents bits 19:16 of that word on cur_speed. cur_speed is cleared when a start is accepted, it stays 0 after a failure, and it changes at no other time.
- R8: On failure, the block reads the PHY register at RXOVRD_ADDR and writes it back with bits 5 and 3 set. It waits at least HOLD_CYCLES cycles, reads the register again, and writes it back with bits 5 and 3 cleared. Other bits are kept in both writes.
- R9: done is a one-cycle pulse at the end of every run, and fail is 1 only in that cycle and only for a failed run.
- R10: start is ignored while a run is in progress: a run produces exactly one done pulse and one pass of register accesses.
- R11: Once raised, reg_req and phy_req hold their address, direction and data stable until the matching acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| max_gen | input | 2 | Configured top generation; 0 means unconfigured (treated as 1) |
| link_timeout | input | TO_W | Cycle budget for each trained-link wait |
| link_up | input | 1 | Link core reports link up |
| link_training | input | 1 | Link core reports training in progress |
| train_en | output | 1 | Enables the link training state machine |
| reg_req | output | 1 | Configuration access request |
| reg_we | output | 1 | Configuration access is a write |
| reg_addr | output | REG_AW | Configuration register address |
| reg_wdata | output | 32 | Configuration write data |
| reg_ack | input | 1 | Configuration access acknowledge |
| reg_rdata | input | 32 | Configuration read data, valid with reg_ack |
| phy_req | output | 1 | PHY register access request |
| phy_we | output | 1 | PHY access is a write |
| phy_addr | output | PHY_AW | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY access acknowledge |
| phy_rdata | input | 16 | PHY read data, valid with phy_ack |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Set with done when the run failed |
| cur_speed | output | 4 | Negotiated speed after a successful run |

## Verification
The bench builds the block with POLL_MAX set to 5 and HOLD_CYCLES set to 20, and drives link_timeout to 150. These values make every poll outcome reachable in short runs: the request bit clearing on the first read, on the last allowed read, and one read too late. The same values let the full recovery pulse and the timeout path finish in a few hundred cycles. The bench sweeps all four max_gen codes against each clear point, so both the skipped and the taken speed-change branch are covered at every boundary. Separate runs hold link_training high after link_up, let the link never come up, and pulse start again mid-run.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int REG_DW     = 32;
    localparam int PHY_DW     = 16;
    localparam int OP_AW      = 16;
    localparam int SPD_W      = 4;
    localparam int SPD_CHG_B  = 17;
    localparam int NEG_SPD_LO = 16;
    localparam int RX_DAT_B   = 5;
    localparam int RX_PLL_B   = 3;

    localparam logic [SPD_W-1:0] GEN_ONE = 4'd1;
    localparam logic [SPD_W-1:0] GEN_TWO = 4'd2;

    typedef enum logic [4:0] {
        S_IDLE, S_CAP_RD, S_CAP_WR, S_WAIT_LINK,
        S_CAP2_RD, S_CAP2_WR, S_SPD_RD, S_SPD_WR, S_POLL,
        S_WAIT_LINK2, S_STAT_RD,
        S_RX_SET_RD, S_RX_SET_WR, S_RX_HOLD, S_RX_CLR_RD, S_RX_CLR_WR
    } seq_state_t;

    typedef struct packed {
        logic              phy;
        logic              we;
        logic [OP_AW-1:0]  addr;
        logic [REG_DW-1:0] data;
    } acc_op_t;

    function automatic acc_op_t mk_op(input logic phy, input logic we,
                                      input logic [OP_AW-1:0] a,
                                      input logic [REG_DW-1:0] d);
        acc_op_t o;
        o.phy  = phy;
        o.we   = we;
        o.addr = a;
        o.data = d;
        return o;
    endfunction

    function automatic logic [REG_DW-1:0] with_speed(input logic [REG_DW-1:0] w,
                                                     input logic [SPD_W-1:0] g);
        logic [REG_DW-1:0] r;
        r = w;
        r[SPD_W-1:0] = g;
        return r;
    endfunction

    function automatic logic [PHY_DW-1:0] rx_override(input logic [PHY_DW-1:0] w,
                                                      input logic on);
        logic [PHY_DW-1:0] r;
        r = w;
        r[RX_DAT_B] = on;
        r[RX_PLL_B] = on;
        return r;
    endfunction

endpackage

// File: rtl/lbs_access_port.sv
module lbs_access_port #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          go_we,
    input  logic [AW-1:0] go_addr,
    input  logic [DW-1:0] go_data,
    output logic          req,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    input  logic          ack,
    input  logic [DW-1:0] rdata_in,
    output logic          done,
    output logic [DW-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= 1'b0;
            we      <= 1'b0;
            addr    <= '0;
            wdata   <= '0;
            done    <= 1'b0;
            rdata_q <= '0;
        end else begin
            done <= 1'b0;
            if (req) begin
                if (ack) begin
                    req     <= 1'b0;
                    done    <= 1'b1;
                    rdata_q <= rdata_in;
                end
            end else if (go) begin
                req   <= 1'b1;
                we    <= go_we;
                addr  <= go_addr;
                wdata <= go_data;
            end
        end
    end

endmodule

// File: rtl/lbs_span_timer.sv
module lbs_span_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt;

    assign expired = run && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import lbs_pkg::*;
#(
    parameter int          REG_AW      = 12,
    parameter int          PHY_AW      = 16,
    parameter int          TO_W        = 20,
    parameter int          POLL_MAX    = 200,
    parameter int          HOLD_CYCLES = 250000,
    parameter logic [15:0] CAP_ADDR    = 16'h007C,
    parameter logic [15:0] STAT_ADDR   = 16'h0080,
    parameter logic [15:0] SPD_ADDR    = 16'h080C,
    parameter logic [15:0] RXOVRD_ADDR = 16'h1005
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        max_gen,
    input  logic [TO_W-1:0]   link_timeout,
    input  logic              link_up,
    input  logic              link_training,
    output logic              train_en,
    output logic              reg_req,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [31:0]       reg_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [15:0]       phy_wdata,
    input  logic              phy_ack,
    input  logic [15:0]       phy_rdata,
    output logic              done,
    output logic              fail,
    output logic [3:0]        cur_speed
);

    localparam int PW = $clog2(POLL_MAX + 1);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);
    localparam logic [HW-1:0] HOLD_LIM  = HW'(HOLD_CYCLES);

    seq_state_t          st;
    acc_op_t             op_q;
    logic                go_q;
    logic                train_q, done_q, fail_q, gen2_q;
    logic [SPD_W-1:0]    speed_q;
    logic [PW-1:0]       poll_q;

    logic                reg_done, phy_done, acc_done;
    logic [REG_DW-1:0]   reg_rd;
    logic [PHY_DW-1:0]   phy_rd;
    logic                link_ok, link_exp, hold_exp;
    logic                wait_run, hold_run;

    // Configuration-space access port
    lbs_access_port #(.AW(REG_AW), .DW(REG_DW)) u_reg_port (
        .clk      (clk),
        .rst      (rst),
        .go       (go_q && !op_q.phy),
        .go_we    (op_q.we),
        .go_addr  (op_q.addr[REG_AW-1:0]),
        .go_data  (op_q.data),
        .req      (reg_req),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ack      (reg_ack),
        .rdata_in (reg_rdata),
        .done     (reg_done),
        .rdata_q  (reg_rd)
    );

    // PHY internal register access port
    lbs_access_port #(.AW(PHY_AW), .DW(PHY_DW)) u_phy_port (
        .clk      (clk),
        .rst      (rst),
        .go       (go_q && op_q.phy),
        .go_we    (op_q.we),
        .go_addr  (op_q.addr[PHY_AW-1:0]),
        .go_data  (op_q.data[PHY_DW-1:0]),
        .req      (phy_req),
        .we       (phy_we),
        .addr     (phy_addr),
        .wdata    (phy_wdata),
        .ack      (phy_ack),
        .rdata_in (phy_rdata),
        .done     (phy_done),
        .rdata_q  (phy_rd)
    );

    assign wait_run = (st == S_WAIT_LINK) || (st == S_WAIT_LINK2);
    assign hold_run = (st == S_RX_HOLD);

    lbs_span_timer #(.W(TO_W)) u_link_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (wait_run),
        .limit   (link_timeout),
        .expired (link_exp)
    );

    lbs_span_timer #(.W(HW)) u_hold_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (hold_run),
        .limit   (HOLD_LIM),
        .expired (hold_exp)
    );

    assign acc_done = reg_done || phy_done;
    assign link_ok  = link_up && !link_training;

    assign train_en  = train_q;
    assign done      = done_q;
    assign fail      = fail_q;
    assign cur_speed = speed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            op_q    <= '0;
            go_q    <= 1'b0;
            train_q <= 1'b0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            gen2_q  <= 1'b0;
            speed_q <= '0;
            poll_q  <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            unique case (st)
                S_IDLE: if (start) begin
                    speed_q <= '0;
                    train_q <= 1'b0;
                    gen2_q  <= (max_gen >= 2'd2);
                    op_q    <= mk_op(1'b0, 1'b0, CAP_ADDR, '0);
                    go_q    <= 1'b1;
                    st      <= S_CAP_RD;
                end
                S_CAP_RD: if (acc_done) begin
                    op_q <= mk_op(1'b0, 1'b1, CAP_ADDR, with_speed(reg_rd, GEN_ONE));
                    go_q <= 1'b1;
                    st   <= S_CAP_WR;
                end
                S_CAP_WR: if (acc_done) begin
                    train_q <= 1'b1;
                    st      <= S_WAIT_LINK;
                end
                S_WAIT_LINK: begin
                    if (link_ok) begin
                        op_q <= mk_op(1'b0, 1'b0, gen2_q ? CAP_ADDR : STAT_ADDR, '0);
                        go_q <= 1'b1;
                        st   <= gen2_q ? S_CAP2_RD : S_STAT_RD;
                    end else if (link_exp) begin
                        op_q <= mk_op(1'b1, 1'b0, RXOVRD_ADDR, '0);
                        go_q <= 1'b1;
                        st   <= S_RX_SET_RD;
                    end
                end
                S_CAP2_RD: if (acc_done) begin
                    op_q <= mk_op(1'b0, 1'b1, CAP_ADDR, with_speed(reg_rd, GEN_TWO));
                    go_q <= 1'b1;
                    st   <= S_CAP2_WR;
                end
                S_CAP2_WR: if (acc_done) begin
                    op_q <= mk_op(1'b0, 1'b0, SPD_ADDR, '0);
                    go_q <= 1'b1;
                    st   <= S_SPD_RD;
                end
                S_SPD_RD: if (acc_done) begin
                    op_q   <= mk_op(1'b0, 1'b1, SPD_ADDR, reg_rd | (REG_DW'(1) << SPD_CHG_B));
                    go_q   <= 1'b1;
                    poll_q <= '0;
                    st     <= S_SPD_WR;
                end
                S_SPD_WR: if (acc_done) begin
                    op_q <= mk_op(1'b0, 1'b0, SPD_ADDR, '0);
                    go_q <= 1'b1;
                    st   <= S_POLL;
                end
                S_POLL: if (acc_done) begin
                    if (!reg_rd[SPD_CHG_B]) begin
                        st <= S_WAIT_LINK2;
                    end else if (poll_q == POLL_LAST) begin
                        op_q <= mk_op(1'b1, 1'b0, RXOVRD_ADDR, '0);
                        go_q <= 1'b1;
                        st   <= S_RX_SET_RD;
                    end else begin
                        poll_q <= poll_q + 1'b1;
                        op_q   <= mk_op(1'b0, 1'b0, SPD_ADDR, '0);
                        go_q   <= 1'b1;
                    end
                end
                S_WAIT_LINK2: begin
                    if (link_ok) begin
                        op_q <= mk_op(1'b0, 1'b0, STAT_ADDR, '0);
                        go_q <= 1'b1;
                        st   <= S_STAT_RD;
                    end else if (link_exp) begin
                        op_q <= mk_op(1'b1, 1'b0, RXOVRD_ADDR, '0);
                        go_q <= 1'b1;
                        st   <= S_RX_SET_RD;
                    end
                end
                S_STAT_RD: if (acc_done) begin
                    speed_q <= reg_rd[NEG_SPD_LO +: SPD_W];
                    done_q  <= 1'b1;
                    st      <= S_IDLE;
                end
                S_RX_SET_RD: if (acc_done) begin
                    op_q <= mk_op(1'b1, 1'b1, RXOVRD_ADDR,
                                  {{(REG_DW-PHY_DW){1'b0}}, rx_override(phy_rd, 1'b1)});
                    go_q <= 1'b1;
                    st   <= S_RX_SET_WR;
                end
                S_RX_SET_WR: if (acc_done) begin
                    st <= S_RX_HOLD;
                end
                S_RX_HOLD: if (hold_exp) begin
                    op_q <= mk_op(1'b1, 1'b0, RXOVRD_ADDR, '0);
                    go_q <= 1'b1;
                    st   <= S_RX_CLR_RD;
                end
                S_RX_CLR_RD: if (acc_done) begin
                    op_q <= mk_op(1'b1, 1'b1, RXOVRD_ADDR,
                                  {{(REG_DW-PHY_DW){1'b0}}, rx_override(phy_rd, 1'b0)});
                    go_q <= 1'b1;
                    st   <= S_RX_CLR_WR;
                end
                S_RX_CLR_WR: if (acc_done) begin
                    done_q <= 1'b1;
                    fail_q <= 1'b1;
                    st     <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker
    import lbs_pkg::*;
#(
    parameter int REG_AW = 12,
    parameter int PHY_AW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              fail,
    input logic [3:0]        cur_speed,
    input logic              reg_req,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_ack,
    input logic              phy_req,
    input logic              phy_we,
    input logic [PHY_AW-1:0] phy_addr,
    input logic [15:0]       phy_wdata,
    input logic              phy_ack
);

    p_reg_hold_r11: assert property (@(posedge clk) disable iff (rst)
        reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we));

    p_phy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        phy_req && !phy_ack |=> phy_req && $stable(phy_addr) && $stable(phy_wdata));

    p_rx_pair_r8: assert property (@(posedge clk) disable iff (rst)
        phy_req && phy_we |-> phy_wdata[RX_DAT_B] == phy_wdata[RX_PLL_B]);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_fail_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    p_speed_moves_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_speed) |-> done || $past(start));

endmodule

bind link_bringup_seq lbs_checker #(.REG_AW(REG_AW), .PHY_AW(PHY_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .fail      (fail),
    .cur_speed (cur_speed),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_ack   (reg_ack),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_ack   (phy_ack)
);

// File: tb/sim_link_bringup_seq.sv
`timescale 1ns/1ps
module sim_link_bringup_seq;

    localparam int POLL     = 5;
    localparam int HOLD     = 20;
    localparam int LINK_DLY = 8;
    localparam int TMO      = 150;
    localparam logic [15:0] A_CAP  = 16'h007C;
    localparam logic [15:0] A_STAT = 16'h0080;
    localparam logic [15:0] A_SPD  = 16'h080C;
    localparam logic [15:0] A_RX   = 16'h1005;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  max_gen = 2'd0;
    logic [19:0] link_timeout = 20'(TMO);
    logic        link_up = 1'b0, link_training = 1'b0;
    logic        train_en;
    logic        reg_req, reg_we, reg_ack = 1'b0;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata = '0;
    logic        phy_req, phy_we, phy_ack = 1'b0;
    logic [15:0] phy_addr, phy_wdata, phy_rdata = '0;
    logic        done, fail;
    logic [3:0]  cur_speed;

    always #2.5 clk = ~clk;

    link_bringup_seq #(.POLL_MAX(POLL), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst(rst), .start(start), .max_gen(max_gen),
        .link_timeout(link_timeout), .link_up(link_up), .link_training(link_training),
        .train_en(train_en), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata), .done(done), .fail(fail),
        .cur_speed(cur_speed)
    );

    // Bench model state
    logic [31:0] m_cap, m_spd, m_stat;
    logic [15:0] m_phy;
    logic [15:0] phy_w [2];
    int phy_w_cyc [2];
    int cyc = 0, tcnt = 0, retrain = 0, rise_cyc = 0, done_cyc = 0;
    int cap_wr = 0, spd_acc = 0, poll_rd = 0, phy_wr = 0, done_cnt = 0;
    int clear_after = 1, train_drop = 0, first_post = -1;
    bit link_works = 1'b1, train_prev = 1'b0, train_at_cap = 1'b0;
    logic got_fail;
    logic [3:0] got_speed;

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Link, register and PHY models, sampled and driven at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (train_en && !train_prev) rise_cyc = cyc;
            train_prev = train_en;
            tcnt = train_en ? tcnt + 1 : 0;
            if (retrain > 0) retrain--;
            link_up       = train_en && link_works && (tcnt >= LINK_DLY);
            link_training = train_en && ((tcnt < train_drop) || (retrain > 0));
            if (done) begin
                done_cnt++;
                got_fail  = fail;
                got_speed = cur_speed;
                done_cyc  = cyc;
            end
            if (reg_req && !reg_ack) begin
                reg_ack = 1'b1;
                if (train_en && first_post < 0) first_post = tcnt;
                if (reg_we) begin
                    if (16'(reg_addr) == A_CAP) begin
                        if (cap_wr == 0) train_at_cap = train_en;
                        cap_wr++;
                        m_cap = reg_wdata;
                    end else if (16'(reg_addr) == A_SPD) begin
                        spd_acc++;
                        m_spd = reg_wdata;
                        if (reg_wdata[17]) retrain = 6;
                    end
                end else begin
                    if (16'(reg_addr) == A_CAP) reg_rdata = m_cap;
                    else if (16'(reg_addr) == A_STAT) reg_rdata = m_stat;
                    else if (16'(reg_addr) == A_SPD) begin
                        spd_acc++;
                        if (m_spd[17]) begin
                            poll_rd++;
                            if (poll_rd >= clear_after) m_spd[17] = 1'b0;
                        end
                        reg_rdata = m_spd;
                    end else reg_rdata = 32'hDEAD_0000;
                end
            end else begin
                reg_ack = 1'b0;
            end
            if (phy_req && !phy_ack) begin
                phy_ack = 1'b1;
                if (phy_we) begin
                    if (phy_wr < 2) begin
                        phy_w[phy_wr] = phy_wdata;
                        phy_w_cyc[phy_wr] = cyc;
                    end
                    phy_wr++;
                    if (phy_addr == A_RX) m_phy = phy_wdata;
                end else begin
                    phy_rdata = (phy_addr == A_RX) ? m_phy : 16'hBAD0;
                end
            end else begin
                phy_ack = 1'b0;
            end
        end
    end

    bit hung = 1'b0;

    task automatic run_case(input int mg, input int clr, input bit works, input int drop,
                            input logic [31:0] capi, input logic [15:0] phyi,
                            input bit restart);
        int d0, n;
        bit g2, efail;
        logic [3:0] egen;
        @(negedge clk);
        g2 = (mg >= 2);
        egen = g2 ? 4'd2 : 4'd1;
        m_cap = capi; m_spd = 32'h0000_0123; m_phy = phyi;
        m_stat = 32'hC0D0_0042 | (32'(egen) << 16);
        link_works = works; clear_after = clr; train_drop = drop;
        cap_wr = 0; spd_acc = 0; poll_rd = 0; phy_wr = 0; first_post = -1;
        max_gen = 2'(mg);
        d0 = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (done_cnt == d0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (done_cnt == d0) begin
            hung = 1'b1;
            chk(1'b0, "R9 watchdog: run never finished", 0, 1);
            return;
        end
        efail = !works || (g2 && clr > POLL);
        chk(got_fail == efail, "R9/R5 fail flag", 64'(got_fail), 64'(efail));
        chk(train_at_cap == 1'b0, "R2 train_en low at capability write", 64'(train_at_cap), 0);
        chk(train_en == 1'b1, "R2 train_en held after run", 64'(train_en), 1);
        chk(m_cap == {capi[31:4], (works && g2) ? 4'd2 : 4'd1}, "R2/R4 capability word",
            64'(m_cap), 64'({capi[31:4], (works && g2) ? 4'd2 : 4'd1}));
        chk(cap_wr == ((works && g2) ? 2 : 1), "R6/R4 capability write count",
            64'(cap_wr), 64'((works && g2) ? 2 : 1));
        if (!g2) begin
            chk(spd_acc == 0, "R6 no speed-control access", 64'(spd_acc), 0);
        end else if (works) begin
            chk(poll_rd == ((clr <= POLL) ? clr : POLL), "R5 poll read count",
                64'(poll_rd), 64'((clr <= POLL) ? clr : POLL));
            chk(m_spd[16:0] == 17'h0123, "R4 speed-control other bits kept",
                64'(m_spd[16:0]), 64'h123);
            chk(m_spd[17] == (clr > POLL), "R5 change bit state at end",
                64'(m_spd[17]), 64'(clr > POLL));
        end
        chk(got_speed == (efail ? 4'd0 : egen), "R7 reported speed",
            64'(got_speed), 64'(efail ? 4'd0 : egen));
        chk(phy_wr == (efail ? 2 : 0), "R8 receiver override write count",
            64'(phy_wr), 64'(efail ? 2 : 0));
        if (efail && phy_wr == 2) begin
            chk(phy_w[0] == (phyi | 16'h0028), "R8 override set word",
                64'(phy_w[0]), 64'(phyi | 16'h0028));
            chk(phy_w[1] == (phyi & ~16'h0028), "R8 override clear word",
                64'(phy_w[1]), 64'(phyi & ~16'h0028));
            chk(phy_w_cyc[1] - phy_w_cyc[0] >= HOLD, "R8 hold length",
                64'(phy_w_cyc[1] - phy_w_cyc[0]), 64'(HOLD));
        end
        if (!works)
            chk(done_cyc - rise_cyc >= TMO, "R3 timeout not early",
                64'(done_cyc - rise_cyc), 64'(TMO));
        if (works && drop > LINK_DLY)
            chk(first_post >= drop, "R3 wait for training to end",
                64'(first_post), 64'(drop));
        repeat (30) @(negedge clk);
        chk(done_cnt == d0 + 1, "R10 exactly one done per run",
            64'(done_cnt - d0), 1);
        chk(!reg_req && !phy_req, "R10 no access after run",
            64'({reg_req, phy_req}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({train_en, done, fail, reg_req, phy_req} == 5'b0, "R1 reset outputs",
            64'({train_en, done, fail, reg_req, phy_req}), 0);
        chk(cur_speed == 4'd0, "R1 reset speed", 64'(cur_speed), 0);

        // Sweep every max_gen code against every poll clear point
        for (int mg = 0; mg < 4; mg++) begin
            for (int clr = 1; clr <= POLL + 1; clr++) begin
                if (!hung)
                    run_case(mg, clr, 1'b1, 0, 32'hFEED_BE00 ^ {mg[7:0], clr[7:0], 16'h00F7},
                             16'h5A14 ^ 16'(clr * 7), 1'b0);
            end
        end
        // R3: link_up seen while still training; must wait for training to end
        if (!hung) run_case(1, 1, 1'b1, 40, 32'h1234_567F, 16'h0000, 1'b0);
        if (!hung) run_case(2, 2, 1'b1, 40, 32'h0000_0003, 16'h0000, 1'b0);
        // R3/R8: link never trains, at both generation settings
        if (!hung) run_case(1, 1, 1'b0, 0, 32'hAAAA_5555, 16'hFFFF, 1'b0);
        if (!hung) run_case(3, 1, 1'b0, 0, 32'h0F0F_0F0A, 16'h0028, 1'b0);
        // R10: second start in the middle of a run
        if (!hung) run_case(2, 3, 1'b1, 0, 32'h8000_0001, 16'h0101, 1'b1);
        if (!hung) run_case(0, 1, 1'b0, 0, 32'h7777_7770, 16'h1234, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule